// File: doc/BRIEF.md
# Pin Interrupt and Wake Event Detector

This block watches one already-filtered pin level and turns it into latched service requests. Control inputs choose edge or level detection and which polarity counts as active. A detected event sets a sticky interrupt status bit when interrupt capture is enabled. The same event sets a separate sticky wake status bit when the wake enable for the current sleep state is set.

A delivery mask gates the combined pending status onto the interrupt output. Software clears each status bit by writing a one to it. One instance is placed per pin. The pin register fields feed the control ports, and a summary stage outside this block gathers the outputs.

Top module: `pin_event_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `irq_sts_o`, `wake_sts_o` and `irq_o` are 0.
- R2: In edge mode (`trig_level_i`=0) with polarity code 2'b00 (high), `irq_sts_o` becomes 1 at the clock edge where `level_i` is 1 and the previous sampled level was 0. A level held at 1 does not set the bit again.
- R3: In edge mode with polarity code 2'b01 (low), a 1-to-0 transition sets `irq_sts_o`, and a 0-to-1 transition does not.
- R4: In edge mode, polarity code 2'b10 (both) sets `irq_sts_o` on either transition, and code 2'b11 never detects an event.
- R5: In level mode (`trig_level_i`=1), code 2'b00 sets `irq_sts_o` on every clock while `level_i` is 1, and code 2'b01 does so while it is 0.
- R6: In level mode, polarity codes 2'b10 and 2'b11 detect no events.
- R7: With `irq_en_i`=0, no event sets `irq_sts_o`, and a status bit that is already set stays set.
- R8: A 1 on `clr_irq_i` clears `irq_sts_o` at the next clock edge, and a 1 on `clr_wake_i` does the same for `wake_sts_o`. If a new event arrives in the same cycle as the clear, the bit stays 1.
- R9: `irq_o` is 1 exactly when `unmask_i` is 1 and at least one of `irq_sts_o` or `wake_sts_o` is 1.
- R10: `sleep_state_i` selects the wake enable: 0 means none, 1 uses `wake_en_i[0]` (S0i3), 2 uses `wake_en_i[1]` (S3), and 3 uses `wake_en_i[2]` (S4/S5). A detected event sets `wake_sts_o` when the selected enable is 1, whatever the value of `irq_en_i`.
- R11: The first clock edge after reset release only records the level and never counts as an edge, even when `level_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 1 | Filtered pin level |
| trig_level_i | input | 1 | 1 = level detection, 0 = edge detection |
| pol_sel_i | input | 2 | 00 high, 01 low, 10 both (edge only), 11 reserved |
| irq_en_i | input | 1 | Allows interrupt status capture |
| unmask_i | input | 1 | 1 lets pending status drive `irq_o` |
| wake_en_i | input | NUM_SLEEP (3) | Wake enable for each sleep state |
| sleep_state_i | input | SEL_W (2) | Current sleep state, 0 = none |
| clr_irq_i | input | 1 | Write-one-to-clear for interrupt status |
| clr_wake_i | input | 1 | Write-one-to-clear for wake status |
| irq_sts_o | output | 1 | Sticky interrupt status |
| wake_sts_o | output | 1 | Sticky wake status |
| irq_o | output | 1 | Service request |

## Verification
The assertions assume that every control input is synchronous to `clk_i` and steady at the sampling edge. They also assume that `level_i` has already been debounced, so a single sample is a real level.

The bench changes inputs only on the falling clock edge. It always returns `level_i` to a known value and lets a full cycle pass before it measures an edge. It issues clears only in cycles where it has decided whether an event coincides with the clear.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  localparam int NUM_STS  = 2;
  localparam int STS_IRQ  = 0;
  localparam int STS_WAKE = 1;
endpackage

// File: rtl/evt_detect.sv
module evt_detect
  import pin_evt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       level_i,
  input  logic       trig_level_i,
  input  logic [1:0] pol_i,
  output logic       evt_o
);
  logic prev_q, seen_q;
  logic rise, fall;
  pol_e pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      seen_q <= 1'b1;
    end
  end

  // no edge until one real sample has been taken
  assign rise = seen_q & level_i & ~prev_q;
  assign fall = seen_q & ~level_i & prev_q;
  assign pol  = pol_e'(pol_i);

  always_comb begin
    evt_o = 1'b0;
    if (trig_level_i) begin
      unique case (pol)
        POL_HIGH: evt_o = level_i;
        POL_LOW:  evt_o = ~level_i;
        default:  evt_o = 1'b0;
      endcase
    end else begin
      unique case (pol)
        POL_HIGH: evt_o = rise;
        POL_LOW:  evt_o = fall;
        POL_BOTH: evt_o = rise | fall;
        default:  evt_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wake_select.sv
module wake_select #(
  parameter int NUM_SLEEP = 3,
  localparam int SEL_W = $clog2(NUM_SLEEP + 1)
) (
  input  logic [SEL_W-1:0]     state_i,
  input  logic [NUM_SLEEP-1:0] wake_en_i,
  output logic                 hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int s = 0; s < NUM_SLEEP; s++) begin
      if (state_i == SEL_W'(s + 1)) hit_o = hit_o | wake_en_i[s];
    end
  end
endmodule

// File: rtl/sticky_bit.sv
module sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
  import pin_evt_pkg::*;
#(
  parameter int NUM_SLEEP = 3,
  localparam int SEL_W = $clog2(NUM_SLEEP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 level_i,
  input  logic                 trig_level_i,
  input  logic [1:0]           pol_sel_i,
  input  logic                 irq_en_i,
  input  logic                 unmask_i,
  input  logic [NUM_SLEEP-1:0] wake_en_i,
  input  logic [SEL_W-1:0]     sleep_state_i,
  input  logic                 clr_irq_i,
  input  logic                 clr_wake_i,
  output logic                 irq_sts_o,
  output logic                 wake_sts_o,
  output logic                 irq_o
);
  logic evt, wake_hit;
  logic [NUM_STS-1:0] sts_set, sts_clr, sts_q;

  evt_detect u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level_i),
    .trig_level_i(trig_level_i),
    .pol_i       (pol_sel_i),
    .evt_o       (evt)
  );

  wake_select #(.NUM_SLEEP(NUM_SLEEP)) u_wsel (
    .state_i  (sleep_state_i),
    .wake_en_i(wake_en_i),
    .hit_o    (wake_hit)
  );

  assign sts_set[STS_IRQ]  = evt & irq_en_i;
  assign sts_set[STS_WAKE] = evt & wake_hit;
  assign sts_clr[STS_IRQ]  = clr_irq_i;
  assign sts_clr[STS_WAKE] = clr_wake_i;

  for (genvar g = 0; g < NUM_STS; g++) begin : g_sts
    sticky_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (sts_set[g]),
      .clr_i (sts_clr[g]),
      .q_o   (sts_q[g])
    );
  end

  assign irq_sts_o  = sts_q[STS_IRQ];
  assign wake_sts_o = sts_q[STS_WAKE];
  assign irq_o      = unmask_i & (|sts_q);
endmodule

// File: rtl/pin_event_unit_chk.sv
module pin_event_unit_chk #(
  parameter int NUM_SLEEP = 3,
  localparam int SEL_W = $clog2(NUM_SLEEP + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 level_i,
  input logic                 trig_level_i,
  input logic [1:0]           pol_sel_i,
  input logic                 irq_en_i,
  input logic                 unmask_i,
  input logic [NUM_SLEEP-1:0] wake_en_i,
  input logic [SEL_W-1:0]     sleep_state_i,
  input logic                 clr_irq_i,
  input logic                 clr_wake_i,
  input logic                 irq_sts_o,
  input logic                 wake_sts_o,
  input logic                 irq_o
);
  a_r2_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_sts_o && !clr_irq_i |=> irq_sts_o);
  a_r5_level_high_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_level_i && pol_sel_i == 2'b00 && level_i && irq_en_i |=> irq_sts_o);
  a_r6_level_rsvd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_level_i && pol_sel_i[1] && !irq_sts_o |=> !irq_sts_o);
  a_r7_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i && !irq_sts_o |=> !irq_sts_o);
  a_r8_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_irq_i && !irq_en_i |=> !irq_sts_o);
  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unmask_i |-> !irq_o);
  a_r9_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_sts_o || wake_sts_o));
  a_r10_no_sleep_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_state_i == '0 && !wake_sts_o |=> !wake_sts_o);
  a_r10_wake_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_sts_o && !clr_wake_i |=> wake_sts_o);
endmodule

bind pin_event_unit pin_event_unit_chk #(.NUM_SLEEP(NUM_SLEEP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .level_i      (level_i),
  .trig_level_i (trig_level_i),
  .pol_sel_i    (pol_sel_i),
  .irq_en_i     (irq_en_i),
  .unmask_i     (unmask_i),
  .wake_en_i    (wake_en_i),
  .sleep_state_i(sleep_state_i),
  .clr_irq_i    (clr_irq_i),
  .clr_wake_i   (clr_wake_i),
  .irq_sts_o    (irq_sts_o),
  .wake_sts_o   (wake_sts_o),
  .irq_o        (irq_o)
);

// File: tb/pin_event_unit_test.sv
`timescale 1ns/1ps
module pin_event_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       level = 1'b0, trig_lvl = 1'b0, irq_en = 1'b0, unmask = 1'b0;
  logic [1:0] pol = 2'b00;
  logic [2:0] wake_en = 3'b000;
  logic [1:0] sleep = 2'b00;
  logic       clr_irq = 1'b0, clr_wake = 1'b0;
  logic       irq_sts, wake_sts, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pin_event_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .trig_level_i(trig_lvl),
    .pol_sel_i(pol), .irq_en_i(irq_en), .unmask_i(unmask), .wake_en_i(wake_en),
    .sleep_state_i(sleep), .clr_irq_i(clr_irq), .clr_wake_i(clr_wake),
    .irq_sts_o(irq_sts), .wake_sts_o(wake_sts), .irq_o(irq)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // settle the level, then clear both status bits
  task automatic prep(logic lvl);
    level = lvl; step(); step();
    clr_irq = 1'b1; clr_wake = 1'b1; step();
    clr_irq = 1'b0; clr_wake = 1'b0;
  endtask

  task automatic t_reset();
    level = 1'b1; trig_lvl = 1'b0; pol = 2'b00; irq_en = 1'b1; unmask = 1'b1;
    step();
    check("R1 irq_sts in reset", irq_sts, 1'b0);
    check("R1 irq_o in reset", irq, 1'b0);
    rst_n = 1'b1; step();
    check("R1 wake_sts after reset", wake_sts, 1'b0);
    step();
    check("R11 first sample no edge", irq_sts, 1'b0);
  endtask

  task automatic t_rise();
    trig_lvl = 1'b0; pol = 2'b00; irq_en = 1'b1;
    prep(1'b0);
    level = 1'b1; step();
    check("R2 rising sets", irq_sts, 1'b1);
    clr_irq = 1'b1; step(); clr_irq = 1'b0;
    check("R8 clear", irq_sts, 1'b0);
    step();
    check("R2 held high no retrigger", irq_sts, 1'b0);
  endtask

  task automatic t_fall();
    trig_lvl = 1'b0; pol = 2'b01; irq_en = 1'b1;
    prep(1'b0);
    level = 1'b1; step();
    check("R3 rising ignored", irq_sts, 1'b0);
    level = 1'b0; step();
    check("R3 falling sets", irq_sts, 1'b1);
  endtask

  task automatic t_both();
    trig_lvl = 1'b0; pol = 2'b10; irq_en = 1'b1;
    prep(1'b0);
    level = 1'b1; step();
    check("R4 both rising", irq_sts, 1'b1);
    clr_irq = 1'b1; step(); clr_irq = 1'b0;
    level = 1'b0; step();
    check("R4 both falling", irq_sts, 1'b1);
    pol = 2'b11;
    prep(1'b0);
    level = 1'b1; step(); level = 1'b0; step();
    check("R4 reserved edge code quiet", irq_sts, 1'b0);
  endtask

  task automatic t_level();
    trig_lvl = 1'b0; pol = 2'b00; irq_en = 1'b1;
    prep(1'b0);
    trig_lvl = 1'b1; level = 1'b1; step();
    check("R5 level high sets", irq_sts, 1'b1);
    clr_irq = 1'b1; step(); clr_irq = 1'b0;
    check("R8 set wins over clear", irq_sts, 1'b1);
    level = 1'b0; step();
    clr_irq = 1'b1; step(); clr_irq = 1'b0;
    check("R5 inactive level clears", irq_sts, 1'b0);
    pol = 2'b01; step();
    check("R5 level low sets", irq_sts, 1'b1);
  endtask

  task automatic t_level_rsvd();
    trig_lvl = 1'b1; pol = 2'b10; irq_en = 1'b1;
    prep(1'b0);
    level = 1'b1; step(); level = 1'b0; step();
    check("R6 level code both quiet", irq_sts, 1'b0);
    pol = 2'b11; level = 1'b1; step();
    check("R6 level code rsvd quiet", irq_sts, 1'b0);
  endtask

  task automatic t_enable();
    trig_lvl = 1'b0; pol = 2'b00; irq_en = 1'b0;
    prep(1'b0);
    level = 1'b1; step();
    check("R7 disabled no capture", irq_sts, 1'b0);
    irq_en = 1'b1; level = 1'b0; step(); level = 1'b1; step();
    irq_en = 1'b0; step(); step();
    check("R7 disable keeps status", irq_sts, 1'b1);
  endtask

  task automatic t_mask();
    unmask = 1'b0; step();
    check("R9 masked no irq", irq, 1'b0);
    unmask = 1'b1; step();
    check("R9 unmasked irq", irq, 1'b1);
  endtask

  task automatic t_wake();
    trig_lvl = 1'b0; pol = 2'b00; irq_en = 1'b0; unmask = 1'b1;
    sleep = 2'd2; wake_en = 3'b010;
    prep(1'b0);
    check("R9 idle no irq", irq, 1'b0);
    level = 1'b1; step();
    check("R10 S3 wake set", wake_sts, 1'b1);
    check("R10 irq_sts untouched", irq_sts, 1'b0);
    check("R9 wake drives irq", irq, 1'b1);
    clr_wake = 1'b1; step(); clr_wake = 1'b0;
    check("R8 wake clear", wake_sts, 1'b0);
    wake_en = 3'b101;
    prep(1'b0);
    level = 1'b1; step();
    check("R10 other enables ignored", wake_sts, 1'b0);
    sleep = 2'd0; wake_en = 3'b111;
    prep(1'b0);
    level = 1'b1; step();
    check("R10 no sleep state no wake", wake_sts, 1'b0);
    sleep = 2'd3; wake_en = 3'b100;
    prep(1'b0);
    level = 1'b1; step();
    check("R10 S4/S5 wake set", wake_sts, 1'b1);
    sleep = 2'd1; wake_en = 3'b001;
    prep(1'b0);
    level = 1'b1; step();
    check("R10 S0i3 wake set", wake_sts, 1'b1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_level_rsvd();
    t_enable();
    t_mask();
    t_wake();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end
endmodule